// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block keeps a small table of the stores issued in the current instruction dispatch group. Each store is recorded as a base identifier, a signed byte offset from that base, and a size in bytes. A load presented on the load inputs is compared against every recorded store in the same cycle. The block raises a single hit flag when any recorded store shares the load's base and touches at least one of the same bytes. The flag feeds a group hazard checker, which can then close the group before the load.

The table holds up to four stores. A store that arrives when the table is full is dropped. A group-end strobe empties the table. If a store arrives in the same cycle as the strobe, the table keeps only that store. The hit flag is combinational and reflects the table as registered before the current clock edge. A load therefore never sees a store that is presented in the same cycle.

Top module: `stld_overlap_det`

## Requirements
- R1: After reset the table is empty and `ld_hit` stays 0 for any load.
- R2: A load hits when a recorded store has the same base and the same offset. This holds even when either size is zero.
- R3: With equal bases and the store offset below the load offset, a hit occurs exactly when store offset plus store size is greater than the load offset.
- R4: With equal bases and the store offset at or above the load offset, a hit occurs exactly when load offset plus load size is greater than the store offset.
- R5: A recorded store whose base differs from the load's base never causes a hit, whatever the offsets.
- R6: `ld_hit` is 1 only while `ld_valid` is 1 and at least one store is recorded.
- R7: At most four stores are recorded per group. A fifth store in the same group is ignored, and a load that overlaps only that store does not hit.
- R8: `grp_end` empties the table at the clock edge. A load in the same cycle as `grp_end`, or in the same cycle as a store, is judged against the table as it stood before that edge.
- R9: A store that arrives together with `grp_end` becomes the only entry of the new group.
- R10: Offsets are signed 32-bit values and sizes are unsigned 8-bit values. End-of-range sums are formed without wrap-around, so an access near the top of the positive range still overlaps correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Record a store this cycle |
| st_base | input | 16 | Store base identifier |
| st_off | input | 32 | Store signed byte offset |
| st_size | input | 8 | Store size in bytes |
| ld_valid | input | 1 | A load is presented for checking |
| ld_base | input | 16 | Load base identifier |
| ld_off | input | 32 | Load signed byte offset |
| ld_size | input | 8 | Load size in bytes |
| grp_end | input | 1 | The current dispatch group ends at this edge |
| ld_hit | output | 1 | The load overlaps a recorded store |

## Verification
The assertions check the occupancy rules on every cycle:
- the table never exceeds four entries;
- a full table does not grow;
- each accepted store adds exactly one entry;
- a group end leaves zero entries, or one entry when a store arrives with it;
- a hit never appears without a valid load and a non-empty table.

The arithmetic of the overlap decision can only be shown by the bench's scenarios. These cover both sides of each interval boundary, the exact-match rule with zero sizes, differing bases, negative offsets and sums near the positive limit. The bench also covers same-cycle ordering between loads, stores and group ends.

// File: rtl/stld_pkg.sv
package stld_pkg;

    localparam int BASE_W = 16;
    localparam int OFF_W  = 32;
    localparam int SIZE_W = 8;
    // Width that holds offset + size without wrap-around.
    localparam int SUM_W  = OFF_W + 2;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [OFF_W-1:0]  off;
        logic [SIZE_W-1:0] size;
    } mem_ref_t;

endpackage

// File: rtl/stld_entry_cmp.sv
module stld_entry_cmp
    import stld_pkg::*;
(
    input  mem_ref_t st_ref,
    input  mem_ref_t ld_ref,
    output logic     hit
);

    logic signed [SUM_W-1:0] st_lo;
    logic signed [SUM_W-1:0] st_hi;
    logic signed [SUM_W-1:0] ld_lo;
    logic signed [SUM_W-1:0] ld_hi;
    logic                    same_base;
    logic                    same_off;

    always_comb begin
        // Sign-extend offsets and zero-extend sizes into the wide sum width.
        st_lo = {{(SUM_W-OFF_W){st_ref.off[OFF_W-1]}}, st_ref.off};
        ld_lo = {{(SUM_W-OFF_W){ld_ref.off[OFF_W-1]}}, ld_ref.off};
        st_hi = st_lo + {{(SUM_W-SIZE_W){1'b0}}, st_ref.size};
        ld_hi = ld_lo + {{(SUM_W-SIZE_W){1'b0}}, ld_ref.size};

        same_base = (st_ref.base == ld_ref.base);
        same_off  = (st_ref.off == ld_ref.off);

        hit = 1'b0;
        if (same_base) begin
            if (same_off) begin
                hit = 1'b1;
            end else if (st_lo < ld_lo) begin
                hit = (st_hi > ld_lo);
            end else begin
                hit = (ld_hi > st_lo);
            end
        end
    end

endmodule

// File: rtl/stld_store_table.sv
module stld_store_table
    import stld_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  mem_ref_t              st_ref,
    input  logic                  grp_end,
    output mem_ref_t [DEPTH-1:0]  ent,
    output logic [CNT_W-1:0]      cnt
);

    typedef struct packed {
        mem_ref_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]     cnt;
    } tbl_state_t;

    tbl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (grp_end) begin
            state_d.cnt = '0;
            state_d.ent = '0;
            if (st_valid) begin
                // A new group opens with this store as its first entry.
                state_d.ent[0] = st_ref;
                state_d.cnt    = CNT_W'(1);
            end
        end else if (st_valid && (state_q.cnt < CNT_W'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (state_q.cnt == CNT_W'(i)) begin
                    state_d.ent[i] = st_ref;
                end
            end
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ent = state_q.ent;
    assign cnt = state_q.cnt;

endmodule

// File: rtl/stld_overlap_det.sv
module stld_overlap_det
    import stld_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [BASE_W-1:0] st_base,
    input  logic [OFF_W-1:0]  st_off,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              ld_valid,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              grp_end,
    output logic              ld_hit
);

    mem_ref_t             st_ref;
    mem_ref_t             ld_ref;
    mem_ref_t [DEPTH-1:0] tbl_ent;
    logic [CNT_W-1:0]     store_cnt;
    logic [DEPTH-1:0]     raw_hit;
    logic [DEPTH-1:0]     live;

    assign st_ref = '{base: st_base, off: st_off, size: st_size};
    assign ld_ref = '{base: ld_base, off: ld_off, size: ld_size};

    stld_store_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .st_ref   (st_ref),
        .grp_end  (grp_end),
        .ent      (tbl_ent),
        .cnt      (store_cnt)
    );

    // One comparator per table slot; only occupied slots take part.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        stld_entry_cmp u_cmp (
            .st_ref (tbl_ent[g]),
            .ld_ref (ld_ref),
            .hit    (raw_hit[g])
        );
        assign live[g] = (store_cnt > CNT_W'(g));
    end

    assign ld_hit = ld_valid && (|(raw_hit & live));

endmodule

// File: rtl/stld_overlap_chk.sv
module stld_overlap_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             ld_valid,
    input logic             grp_end,
    input logic             ld_hit,
    input logic [CNT_W-1:0] cnt
);

    AST_HIT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> (ld_valid && (cnt != '0))); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH)); // R7

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_end && (cnt == CNT_W'(DEPTH))) |=> (cnt == CNT_W'(DEPTH))); // R7

    AST_STORE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_end && st_valid && (cnt < CNT_W'(DEPTH))) |=> (cnt == $past(cnt) + CNT_W'(1))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_end && !st_valid) |=> $stable(cnt)); // R7

    AST_GRP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end && !st_valid) |=> (cnt == '0)); // R8

    AST_GRP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end && st_valid) |=> (cnt == CNT_W'(1))); // R9

endmodule

bind stld_overlap_det stld_overlap_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .ld_valid (ld_valid),
    .grp_end  (grp_end),
    .ld_hit   (ld_hit),
    .cnt      (store_cnt)
);

// File: tb/stld_overlap_det_tb.sv
module stld_overlap_det_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [15:0] st_base = '0;
    logic [31:0] st_off = '0;
    logic [7:0]  st_size = '0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_base = '0;
    logic [31:0] ld_off = '0;
    logic [7:0]  ld_size = '0;
    logic        grp_end = 1'b0;
    logic        ld_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  exp;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stld_overlap_det u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_base(st_base), .st_off(st_off), .st_size(st_size),
        .ld_valid(ld_valid), .ld_base(ld_base), .ld_off(ld_off), .ld_size(ld_size),
        .grp_end(grp_end), .ld_hit(ld_hit)
    );

    // Driver: one cycle of stimulus plus its expected hit value.
    task automatic cyc(input logic sv, input logic [15:0] sb, input logic [31:0] so,
                       input logic [7:0] ss, input logic lv, input logic [15:0] lb,
                       input logic [31:0] lo, input logic [7:0] ls, input logic ge,
                       input logic exp, input string tag);
        exp_item_t it;
        @(negedge clk);
        st_valid = sv; st_base = sb; st_off = so; st_size = ss;
        ld_valid = lv; ld_base = lb; ld_off = lo; ld_size = ls;
        grp_end = ge;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic store(input logic [15:0] b, input logic [31:0] o, input logic [7:0] s,
                         input logic ge, input string tag);
        cyc(1'b1, b, o, s, 1'b0, 16'h0, 32'h0, 8'h0, ge, 1'b0, tag);
    endtask

    task automatic load(input logic [15:0] b, input logic [31:0] o, input logic [7:0] s,
                        input logic exp, input string tag);
        cyc(1'b0, 16'h0, 32'h0, 8'h0, 1'b1, b, o, s, 1'b0, exp, tag);
    endtask

    // Monitor: compare a quarter period after each falling edge.
    initial begin
        exp_item_t it;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (ld_hit !== it.exp) begin
                    errors++;
                    $display("FAIL %s: ld_hit actual %b expected %b", it.tag, ld_hit, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, load after reset sees an empty table.
        cyc(1'b1, 16'h11, 32'd100, 8'd8, 1'b1, 16'h11, 32'd100, 8'd8, 1'b0, 1'b0, "R1 in reset");
        cyc(1'b0, 16'h0, 32'h0, 8'h0, 1'b0, 16'h0, 32'h0, 8'h0, 1'b0, 1'b0, "R1 in reset idle");
        @(negedge clk); rst_n = 1'b1;
        load(16'h11, 32'd100, 8'd8, 1'b0, "R1 empty after reset");

        // R8: a load in the same cycle as a store does not see it.
        cyc(1'b1, 16'h11, 32'd100, 8'd8, 1'b1, 16'h11, 32'd100, 8'd8, 1'b0, 1'b0, "R8 same-cycle store");
        // R2: exact match, zero load size.
        load(16'h11, 32'd100, 8'd0, 1'b1, "R2 exact zero size");
        // R3: store below load, boundary on both sides.
        load(16'h11, 32'd107, 8'd4, 1'b1, "R3 last byte");
        load(16'h11, 32'd108, 8'd4, 1'b0, "R3 just past");
        // R4: store at or above load.
        load(16'h11, 32'd96, 8'd4, 1'b0, "R4 ends at store");
        load(16'h11, 32'd96, 8'd5, 1'b1, "R4 one byte over");
        // R5: different base never hits.
        load(16'h22, 32'd100, 8'd8, 1'b0, "R5 other base");
        // R6: no valid load, no hit.
        cyc(1'b0, 16'h0, 32'h0, 8'h0, 1'b0, 16'h11, 32'd100, 8'd8, 1'b0, 1'b0, "R6 ld_valid low");
        // R8: load with grp_end still sees the old table, then it is empty.
        cyc(1'b0, 16'h0, 32'h0, 8'h0, 1'b1, 16'h11, 32'd100, 8'd8, 1'b1, 1'b1, "R8 load with group end");
        load(16'h11, 32'd100, 8'd8, 1'b0, "R8 cleared");

        // R7: capacity of four.
        for (int i = 1; i <= 5; i++) store(16'(i), 32'd0, 8'd4, 1'b0, "R7 fill");
        load(16'd4, 32'd2, 8'd1, 1'b1, "R7 fourth kept");
        load(16'd5, 32'd0, 8'd4, 1'b0, "R7 fifth dropped");
        load(16'd1, 32'd3, 8'd1, 1'b1, "R7 first kept");

        // R9: store with group end is the only entry.
        store(16'd9, 32'd0, 8'd4, 1'b1, "R9 store with group end");
        load(16'd1, 32'd0, 8'd4, 1'b0, "R9 old entry gone");
        load(16'd9, 32'd0, 8'd4, 1'b1, "R9 new entry");

        // R10: negative offsets and sums near the positive limit.
        store(16'd3, 32'hFFFF_FFF8, 8'd8, 1'b1, "R10 store -8");
        load(16'd3, 32'd0, 8'd4, 1'b0, "R10 -8+8 not past 0");
        store(16'd3, 32'hFFFF_FFF8, 8'd9, 1'b1, "R10 store -8 size 9");
        load(16'd3, 32'd0, 8'd4, 1'b1, "R10 -8+9 past 0");
        store(16'd3, 32'h7FFF_FFF0, 8'h20, 1'b1, "R10 store near top");
        load(16'd3, 32'h7FFF_FFF8, 8'd1, 1'b1, "R10 no wrap");
        load(16'd3, 32'h8000_0000, 8'hFF, 1'b0, "R10 most negative");

        cyc(1'b0, 16'h0, 32'h0, 8'h0, 1'b0, 16'h0, 32'h0, 8'h0, 1'b0, 1'b0, "R6 idle end");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule